// File: doc/BRIEF.md
# Transport-Triggered Move-Bus Datapath

This block is a small exposed-datapath core. It has no opcodes. Each instruction word holds a few move slots, and every slot copies one value from a source onto a destination over its own bus. A source can be a register, a sign-extended immediate or a functional unit's result port. A destination can be a register, a unit's operand latch or a unit's trigger port.

A unit computes only when a move lands on its trigger port. The trigger value is combined with whatever the unit's operand latch holds at that moment. The result shows up on the unit's result port after a fixed number of cycles, and a later move must carry it away. The core contains a register file, a one-cycle adder and a three-stage pipelined multiplier. It has no interlocks. A program that reads a result too early simply gets the stale value.

An upstream sequencer feeds instructions through a valid/data pair. The value on each move bus is visible at the ports, and this is how the program's data leaves the core.

Top module: `tta_core`

## Requirements
- R1: After reset every register, both operand latches and both result ports read as zero.
- R2: Slot s occupies `instr_data[17*s+16 : 17*s]`. Inside a slot, bit 16 is the slot's valid bit, bits 15:12 are the source id, bits 11:8 are the destination id and bits 7:0 are the immediate. A slot moves data only when both `instr_valid` and its valid bit are 1. Otherwise its `bus_valid` bit is 0, its `bus_data` is zero and it changes no state.
- R3: Source ids 0 to 7 read registers r0 to r7. Id 8 reads the adder result and id 9 reads the multiplier result. Id 15 reads the immediate, sign-extended to 32 bits. Ids 10 to 14 read zero.
- R4: Destination ids 0 to 7 write registers r0 to r7. Id 8 is the adder operand, 9 the adder trigger, 10 the multiplier operand and 11 the multiplier trigger. Ids 12 to 15 discard the value and change no state.
- R5: A move to an operand latch stores the value and starts no operation, so the result ports are unchanged.
- R6: A move to the adder trigger makes the adder result equal operand plus trigger value, modulo 2^32. A move in the next instruction can read it.
- R7: A move to the multiplier trigger produces the low 32 bits of operand times trigger value. A move in the third instruction cycle after the trigger can read it. Reads before that return the old result.
- R8: The multiplier accepts a trigger in every cycle, and its results appear in trigger order.
- R9: A result port holds its value until a later trigger's result replaces it.
- R10: All moves in one instruction read their sources before any destination is written. A register read and a write to the same register in the same instruction see the old value.
- R11: A trigger move uses the operand latch value from before the instruction, even when the same instruction also writes that latch.
- R12: When two active slots target the same destination, the higher-numbered slot's value is kept.
- R13: A result source may be moved straight into another unit's trigger port without passing through a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented in this cycle |
| instr_data | input | 34 | Two 17-bit move slots, slot 0 in the low bits |
| bus_valid | output | 2 | One bit per slot: the slot moves data this cycle |
| bus_data | output | 64 | Value on each move bus, slot 0 in the low 32 bits |

## Verification
A corrupted register or operand latch stays hidden until a move reads it. Once a move reads it, the wrong value appears on that slot's `bus_data` in the same cycle. A faulty result pipeline appears either as a value that arrives one cycle early or late or as a result that changes without a trigger. Both are visible on the first read after the fault.

Every instruction the bench issues is compared bus by bus against a reference model of the state. Any wrong internal state therefore surfaces at the first move that sources it. Directed cases pin down the exact latency edges, same-instruction ordering and slot priority with literal expected values.

// File: rtl/tta_pkg.sv
package tta_pkg;
   localparam int ID_W  = 4;
   localparam int IMM_W = 8;

   localparam logic [ID_W-1:0] SRC_ADD_RES = 4'd8;
   localparam logic [ID_W-1:0] SRC_MUL_RES = 4'd9;
   localparam logic [ID_W-1:0] SRC_IMM     = 4'd15;

   localparam logic [ID_W-1:0] DST_ADD_OPD = 4'd8;
   localparam logic [ID_W-1:0] DST_ADD_TRG = 4'd9;
   localparam logic [ID_W-1:0] DST_MUL_OPD = 4'd10;
   localparam logic [ID_W-1:0] DST_MUL_TRG = 4'd11;

   typedef struct packed {
      logic             vld;
      logic [ID_W-1:0]  src;
      logic [ID_W-1:0]  dst;
      logic [IMM_W-1:0] imm;
   } move_slot_t;

   localparam int SLOT_W = $bits(move_slot_t);
endpackage

// File: rtl/tta_regfile.sv
module tta_regfile #(
   parameter int DATA_W    = 32,
   parameter int NUM_REGS  = 8,
   parameter int NUM_PORTS = 2,
   localparam int AW       = $clog2(NUM_REGS)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_PORTS-1:0][AW-1:0]       rd_addr,
   output logic [NUM_PORTS-1:0][DATA_W-1:0]   rd_data,
   input  logic [NUM_PORTS-1:0]               wr_en,
   input  logic [NUM_PORTS-1:0][AW-1:0]       wr_addr,
   input  logic [NUM_PORTS-1:0][DATA_W-1:0]   wr_data
);
   logic [NUM_REGS-1:0][DATA_W-1:0] mem;

   if (NUM_REGS < 2) begin : g_bad_depth
      $error("tta_regfile: NUM_REGS must be at least 2");
   end

   // Ports are visited in ascending order, so the highest port wins a clash.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem <= '0;
      end else begin
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr_en[p]) mem[wr_addr[p]] <= wr_data[p];
         end
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
      assign rd_data[p] = mem[rd_addr[p]];
   end

   // R12: the top port always owns the register it writes
   for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
      a_r12_top_port_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en[NUM_PORTS-1] && wr_addr[NUM_PORTS-1] == AW'(k))
         |=> mem[k] == $past(wr_data[NUM_PORTS-1]));
   end
endmodule

// File: rtl/tta_fu.sv
module tta_fu #(
   parameter int DATA_W = 32,
   parameter int LAT    = 1,
   parameter bit IS_MUL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              opd_we,
   input  logic [DATA_W-1:0] opd_din,
   input  logic              trg_we,
   input  logic [DATA_W-1:0] trg_din,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] opd_q;
   logic [DATA_W-1:0] calc;
   logic              fin;

   if (LAT < 1) begin : g_bad_lat
      $error("tta_fu: LAT must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      opd_q <= '0;
      else if (opd_we) opd_q <= opd_din;
   end

   if (IS_MUL) begin : g_mul
      assign calc = opd_q * trg_din;
   end else begin : g_add
      assign calc = opd_q + trg_din;
   end

   if (LAT == 1) begin : g_direct
      assign fin = trg_we;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      res <= '0;
         else if (trg_we) res <= calc;
      end
   end else begin : g_pipe
      logic [LAT-2:0]             pv;
      logic [LAT-2:0][DATA_W-1:0] pd;
      assign fin = pv[LAT-2];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pv  <= '0;
            pd  <= '0;
            res <= '0;
         end else begin
            pv[0] <= trg_we;
            pd[0] <= calc;
            for (int i = 1; i < LAT-1; i++) begin
               pv[i] <= pv[i-1];
               pd[i] <= pd[i-1];
            end
            if (pv[LAT-2]) res <= pd[LAT-2];
         end
      end
   end

   // R5: an operand move is held in the latch
   a_r5_operand_latched: assert property (@(posedge clk) disable iff (!rst_n)
      opd_we |=> opd_q == $past(opd_din));

   // R9: the result port changes only when a result leaves the unit
   a_r9_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> $stable(res));
endmodule

// File: rtl/tta_core.sv
module tta_core
   import tta_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_REGS  = 8,
   parameter int NUM_SLOTS = 2,
   parameter int ADD_LAT   = 1,
   parameter int MUL_LAT   = 3,
   localparam int AW       = $clog2(NUM_REGS),
   localparam int INSTR_W  = NUM_SLOTS * SLOT_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          instr_valid,
   input  logic [INSTR_W-1:0]            instr_data,
   output logic [NUM_SLOTS-1:0]          bus_valid,
   output logic [NUM_SLOTS*DATA_W-1:0]   bus_data
);
   localparam logic [ID_W-1:0] REG_LIMIT = ID_W'(NUM_REGS);

   if (NUM_REGS < 2 || NUM_REGS > 8) begin : g_bad_regs
      $error("tta_core: NUM_REGS must lie in 2..8");
   end
   if (DATA_W <= IMM_W) begin : g_bad_width
      $error("tta_core: DATA_W must exceed the immediate width");
   end
   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("tta_core: at least one slot is needed");
   end

   move_slot_t                      slot [NUM_SLOTS];
   logic [NUM_SLOTS-1:0]            act;
   logic [NUM_SLOTS-1:0][DATA_W-1:0] mv;

   logic [NUM_SLOTS-1:0][AW-1:0]     rf_ra;
   logic [NUM_SLOTS-1:0][DATA_W-1:0] rf_rd;
   logic [NUM_SLOTS-1:0]             rf_we;
   logic [NUM_SLOTS-1:0][AW-1:0]     rf_wa;

   logic [DATA_W-1:0] add_res, mul_res;
   logic              add_opd_we, add_trg_we, mul_opd_we, mul_trg_we;
   logic [DATA_W-1:0] add_opd_d, add_trg_d, mul_opd_d, mul_trg_d;

   // Source side: every slot reads from the state before this edge.
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic [DATA_W-1:0] sel;

      assign slot[s] = move_slot_t'(instr_data[s*SLOT_W +: SLOT_W]);
      assign act[s]  = instr_valid & slot[s].vld;
      assign rf_ra[s] = slot[s].src[AW-1:0];

      always_comb begin
         sel = '0;
         if (slot[s].src < REG_LIMIT) begin
            sel = rf_rd[s];
         end else begin
            case (slot[s].src)
               SRC_ADD_RES: sel = add_res;
               SRC_MUL_RES: sel = mul_res;
               SRC_IMM:     sel = {{(DATA_W-IMM_W){slot[s].imm[IMM_W-1]}}, slot[s].imm};
               default:     sel = '0;
            endcase
         end
      end

      assign mv[s]    = act[s] ? sel : '0;
      assign rf_we[s] = act[s] && (slot[s].dst < REG_LIMIT);
      assign rf_wa[s] = slot[s].dst[AW-1:0];

      assign bus_valid[s]                = act[s];
      assign bus_data[s*DATA_W +: DATA_W] = mv[s];
   end

   // Destination side for the units: higher slots override lower ones.
   always_comb begin
      add_opd_we = 1'b0; add_opd_d = '0;
      add_trg_we = 1'b0; add_trg_d = '0;
      mul_opd_we = 1'b0; mul_opd_d = '0;
      mul_trg_we = 1'b0; mul_trg_d = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (act[s]) begin
            case (slot[s].dst)
               DST_ADD_OPD: begin add_opd_we = 1'b1; add_opd_d = mv[s]; end
               DST_ADD_TRG: begin add_trg_we = 1'b1; add_trg_d = mv[s]; end
               DST_MUL_OPD: begin mul_opd_we = 1'b1; mul_opd_d = mv[s]; end
               DST_MUL_TRG: begin mul_trg_we = 1'b1; mul_trg_d = mv[s]; end
               default: ;
            endcase
         end
      end
   end

   tta_regfile #(
      .DATA_W    (DATA_W),
      .NUM_REGS  (NUM_REGS),
      .NUM_PORTS (NUM_SLOTS)
   ) i_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (rf_ra),
      .rd_data (rf_rd),
      .wr_en   (rf_we),
      .wr_addr (rf_wa),
      .wr_data (mv)
   );

   tta_fu #(
      .DATA_W (DATA_W),
      .LAT    (ADD_LAT),
      .IS_MUL (1'b0)
   ) i_add (
      .clk     (clk),
      .rst_n   (rst_n),
      .opd_we  (add_opd_we),
      .opd_din (add_opd_d),
      .trg_we  (add_trg_we),
      .trg_din (add_trg_d),
      .res     (add_res)
   );

   tta_fu #(
      .DATA_W (DATA_W),
      .LAT    (MUL_LAT),
      .IS_MUL (1'b1)
   ) i_mul (
      .clk     (clk),
      .rst_n   (rst_n),
      .opd_we  (mul_opd_we),
      .opd_din (mul_opd_d),
      .trg_we  (mul_trg_we),
      .trg_din (mul_trg_d),
      .res     (mul_res)
   );

   // R2: with no instruction presented, no bus carries anything
   a_r2_idle_buses: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> (bus_valid == '0 && bus_data == '0));
endmodule

// File: tb/test_tta_core.sv
`timescale 1ns/1ps
module test_tta_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [33:0] instr_data = '0;
   logic [1:0]  bus_valid;
   logic [63:0] bus_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_reg [8];
   logic [31:0] m_aopd, m_ares, m_mopd, m_mres;
   logic        m_msv [2];
   logic [31:0] m_msd [2];

   always #4 clk = ~clk;

   tta_core i_tta_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr_data  (instr_data),
      .bus_valid   (bus_valid),
      .bus_data    (bus_data)
   );

   function automatic logic [16:0] mv(input logic [3:0] src, input logic [3:0] dst,
                                      input logic [7:0] imm);
      return {1'b1, src, dst, imm};
   endfunction

   function automatic logic [31:0] src_val(input logic [3:0] src, input logic [7:0] imm);
      if (src < 4'd8) return m_reg[src[2:0]];
      case (src)
         4'd8:  return m_ares;
         4'd9:  return m_mres;
         4'd15: return {{24{imm[7]}}, imm};
         default: return 32'd0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [16:0] s1, input logic [16:0] s0,
                       input string tag);
      logic [16:0] sl [2];
      logic        a [2];
      logic [31:0] ev [2];
      logic [31:0] nreg [8];
      logic [31:0] naop, nmop, atv, mtv;
      logic        at, mt;
      @(negedge clk);
      instr_valid = v;
      instr_data  = {s1, s0};
      #1;
      sl[0] = s0; sl[1] = s1;
      for (int s = 0; s < 2; s++) begin
         a[s]  = v & sl[s][16];
         ev[s] = a[s] ? src_val(sl[s][15:12], sl[s][7:0]) : 32'd0;
         chk(tag, bus_data[s*32 +: 32], ev[s]);
         chk(tag, {31'd0, bus_valid[s]}, {31'd0, a[s]});
      end
      nreg = m_reg; naop = m_aopd; nmop = m_mopd;
      at = 1'b0; mt = 1'b0; atv = '0; mtv = '0;
      for (int s = 0; s < 2; s++) begin
         if (a[s]) begin
            case (sl[s][11:8])
               4'd8:  naop = ev[s];
               4'd9:  begin at = 1'b1; atv = ev[s]; end
               4'd10: nmop = ev[s];
               4'd11: begin mt = 1'b1; mtv = ev[s]; end
               default: if (sl[s][11:8] < 4'd8) nreg[sl[s][10:8]] = ev[s];
            endcase
         end
      end
      if (at) m_ares = m_aopd + atv;
      if (m_msv[1]) m_mres = m_msd[1];
      m_msv[1] = m_msv[0]; m_msd[1] = m_msd[0];
      m_msv[0] = mt;       m_msd[0] = m_mopd * mtv;
      m_aopd = naop; m_mopd = nmop; m_reg = nreg;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1 actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [16:0] r0, r1;
      for (int k = 0; k < 8; k++) m_reg[k] = '0;
      m_aopd = '0; m_ares = '0; m_mopd = '0; m_mres = '0;
      m_msv[0] = 1'b0; m_msv[1] = 1'b0; m_msd[0] = '0; m_msd[1] = '0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of every register and both result ports
      for (int k = 0; k < 8; k += 2)
         step(1'b1, mv(4'(k+1), 4'd12, 8'd0), mv(4'(k), 4'd12, 8'd0), "R1");
      step(1'b1, mv(4'd9, 4'd13, 8'd0), mv(4'd8, 4'd13, 8'd0), "R1");
      chk("R1", bus_data[31:0] | bus_data[63:32], 32'd0);

      // R2: nothing moves without instr_valid or a slot valid bit
      step(1'b0, mv(4'd15, 4'd6, 8'h55), mv(4'd15, 4'd6, 8'h55), "R2");
      chk("R2", {30'd0, bus_valid}, 32'd0);
      step(1'b1, {1'b0, 4'd15, 4'd6, 8'h66}, 17'd0, "R2");
      step(1'b1, 17'd0, mv(4'd6, 4'd12, 8'd0), "R2");
      chk("R2", bus_data[31:0], 32'd0);

      // R3: sign-extended immediate and reserved source ids
      step(1'b1, mv(4'd12, 4'd13, 8'd0), mv(4'd15, 4'd1, 8'h80), "R3");
      chk("R3", bus_data[63:32], 32'd0);
      step(1'b1, 17'd0, mv(4'd1, 4'd12, 8'd0), "R3");
      chk("R3", bus_data[31:0], 32'hFFFF_FF80);

      // R4: discarded destinations leave all state alone
      step(1'b1, mv(4'd15, 4'd15, 8'h7F), mv(4'd15, 4'd14, 8'h3C), "R4");
      for (int k = 0; k < 8; k += 2)
         step(1'b1, mv(4'(k+1), 4'd12, 8'd0), mv(4'(k), 4'd12, 8'd0), "R4");

      // R11: operand and trigger in one instruction use the old operand (0)
      step(1'b1, mv(4'd15, 4'd9, 8'd7), mv(4'd15, 4'd8, 8'd5), "R11");
      step(1'b1, 17'd0, mv(4'd8, 4'd12, 8'd0), "R11");
      chk("R11", bus_data[31:0], 32'd7);
      // R5: operand move alone leaves the result untouched
      step(1'b1, 17'd0, mv(4'd15, 4'd8, 8'd5), "R5");
      step(1'b1, 17'd0, mv(4'd8, 4'd12, 8'd0), "R5");
      chk("R5", bus_data[31:0], 32'd7);
      // R6: add 5 + 7 readable in the next instruction
      step(1'b1, 17'd0, mv(4'd15, 4'd9, 8'd7), "R6");
      step(1'b1, 17'd0, mv(4'd8, 4'd12, 8'd0), "R6");
      chk("R6", bus_data[31:0], 32'd12);

      // R7: multiply 3 * 4 visible only in the third cycle after the trigger
      step(1'b1, 17'd0, mv(4'd15, 4'd10, 8'd3), "R7");
      step(1'b1, 17'd0, mv(4'd15, 4'd11, 8'd4), "R7");
      step(1'b1, 17'd0, mv(4'd9, 4'd12, 8'd0), "R7");
      chk("R7", bus_data[31:0], 32'd0);
      step(1'b1, 17'd0, mv(4'd9, 4'd12, 8'd0), "R7");
      chk("R7", bus_data[31:0], 32'd0);
      step(1'b1, 17'd0, mv(4'd9, 4'd12, 8'd0), "R7");
      chk("R7", bus_data[31:0], 32'd12);

      // R8: back-to-back triggers emerge in order
      step(1'b1, 17'd0, mv(4'd15, 4'd11, 8'd5), "R8");
      step(1'b1, 17'd0, mv(4'd15, 4'd11, 8'd6), "R8");
      step(1'b1, 17'd0, mv(4'd15, 4'd11, 8'd7), "R8");
      step(1'b1, 17'd0, mv(4'd9, 4'd12, 8'd0), "R8");
      chk("R8", bus_data[31:0], 32'd15);
      step(1'b1, 17'd0, mv(4'd9, 4'd12, 8'd0), "R8");
      chk("R8", bus_data[31:0], 32'd18);
      step(1'b1, 17'd0, mv(4'd9, 4'd12, 8'd0), "R8");
      chk("R8", bus_data[31:0], 32'd21);

      // R9: results hold across idle cycles
      repeat (4) step(1'b0, 17'd0, 17'd0, "R9");
      step(1'b1, mv(4'd9, 4'd12, 8'd0), mv(4'd8, 4'd12, 8'd0), "R9");
      chk("R9", bus_data[31:0], 32'd12);
      chk("R9", bus_data[63:32], 32'd21);

      // R10: same-instruction read of a register being written sees the old value
      step(1'b1, 17'd0, mv(4'd15, 4'd3, 8'd9), "R10");
      step(1'b1, mv(4'd3, 4'd4, 8'd0), mv(4'd15, 4'd3, 8'h11), "R10");
      chk("R10", bus_data[63:32], 32'd9);
      step(1'b1, mv(4'd3, 4'd12, 8'd0), mv(4'd4, 4'd12, 8'd0), "R10");
      chk("R10", bus_data[31:0], 32'd9);
      chk("R10", bus_data[63:32], 32'h11);

      // R12: higher slot wins on a shared destination
      step(1'b1, mv(4'd15, 4'd5, 8'h22), mv(4'd15, 4'd5, 8'h33), "R12");
      step(1'b1, 17'd0, mv(4'd5, 4'd12, 8'd0), "R12");
      chk("R12", bus_data[31:0], 32'h22);

      // R13: adder result bypassed straight into the multiplier trigger
      step(1'b1, mv(4'd15, 4'd10, 8'd2), mv(4'd15, 4'd8, 8'd10), "R13");
      step(1'b1, 17'd0, mv(4'd15, 4'd9, 8'd1), "R13");
      step(1'b1, 17'd0, mv(4'd8, 4'd11, 8'd0), "R13");
      repeat (2) step(1'b1, 17'd0, 17'd0, "R13");
      step(1'b1, 17'd0, mv(4'd9, 4'd12, 8'd0), "R13");
      chk("R13", bus_data[31:0], 32'd22);

      // R3 R4: random moves compared with the reference model
      for (int n = 0; n < 400; n++) begin
         r0 = {($urandom % 8) != 0, 4'($urandom), 4'($urandom), 8'($urandom)};
         r1 = {($urandom % 8) != 0, 4'($urandom), 4'($urandom), 8'($urandom)};
         step(($urandom % 10) != 0, r1, r0, "R4");
      end

      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule